// File: doc/BRIEF.md
# Command and interrupt status register

This block sits between a host register port and the two execution engines of a network controller: a command unit, which runs transmit and configuration work, and a receive unit. The host writes a 16-bit command word that carries a code for each engine, an interrupt mask bit and a software-interrupt request. It also writes a pointer register that gives the operand of the next command. Each legal code is latched together with a snapshot of the pointer and offered to its engine through a valid/accept handshake. The field reads back as the pending code until the engine takes it, and then reads zero. The host polls for zero before it issues the next command to that engine.

Event pulses from the engines set cause bits in a 16-bit status word. The host clears a cause bit by writing a one to it. A registered interrupt line is raised while any unmasked cause, or a software interrupt, is pending. The status word also shows the live state codes of both engines. It has a sticky error flag that records a command that was dropped, either because its engine was still busy or because the code is undefined.

Top module: `nic_cmd_stat`

## Requirements
- R1: After a synchronous reset: no cause bit set, both command fields zero with valid low, mask bit 8 set (command word reads 0x0100), interrupt low, error flag clear and pointer zero.
- R2: The status word (address 0) has these fields:
  - causes at bit 15 (command done), 14 (frame received), 13 (command unit left active), 12 (receiver left ready), 11 (management cycle done), 10 (software interrupt) and 8 (flow-control pause);
  - the command-unit state input at bits 7:6 and the receive-unit state input at bits 5:2;
  - the sticky error flag at bit 0.
  Every other bit reads zero.
- R3: A pending code reads back in its field until the engine accepts it: command unit at bits 7:4 and receive unit at bits 2:0 of the command word (address 1). While it waits, valid stays high and the code and pointer stay stable. One cycle after valid and accept are both high, valid falls and the field reads zero.
- R4: A write of a legal nonzero code to an idle field raises that engine's valid one cycle later. The pointer (address 2) is snapshotted at that moment. A later pointer write does not alter the operand already offered.
- R5: A nonzero code written to a field that is still pending is discarded and sets the error flag. A zero field in a command write leaves that engine's pending command untouched and raises no error.
- R6: An undefined code is never issued and sets the error flag. Command unit: 3 and 8–15 are undefined. Receive unit: 3 and 5 are undefined.
- R7: An event pulse sets its cause bit. Event input bit k maps to status bit 8+k. A status write clears the cause bits where the written data has a one under mask 0xFD00. A clear and a pulse on the same bit in the same cycle leave the bit set.
- R8: The interrupt output is registered. It changes one cycle after the cause bits or the mask change.
- R9: Command bit 8 masks every cause except the software interrupt from the interrupt output. The bit reads back in the command word.
- R10: Writing command bit 9 sets status bit 10. This raises the interrupt even while masked. Bit 9 always reads back zero.
- R11: Event input bit 1 and status bit 9 never set anything. Address 3 reads zero and ignores writes. The error flag is cleared by writing a one to status bit 0.
- R12: A read returns the addressed register on `rd_data` one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 status, 1 command, 2 pointer) |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Registered read data |
| ev_in | input | 8 | Event pulses, bit k sets status bit 8+k |
| cu_state | input | 2 | Command-unit state code shown in status |
| ru_state | input | 4 | Receive-unit state code shown in status |
| cu_valid | output | 1 | Command-unit command offered |
| cu_code | output | 4 | Command-unit code |
| cu_ptr | output | 32 | Operand pointer for the command unit |
| cu_accept | input | 1 | Command unit takes the command |
| ru_valid | output | 1 | Receive-unit command offered |
| ru_code | output | 3 | Receive-unit code |
| ru_ptr | output | 32 | Operand pointer for the receive unit |
| ru_accept | input | 1 | Receive unit takes the command |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties are checked on every cycle. They cover these rules:
- an offered command is held unchanged until accepted and withdrawn right after;
- only legal codes ever reach an engine;
- an event pulse is never lost to a simultaneous clear;
- the interrupt stays low when no cause is pending;
- the interrupt stays low when the mask is set and no software interrupt is pending.

Other behaviour can only be shown by the bench's scenarios:
- the exact read-back encodings of both words;
- the pointer snapshot;
- the error flag on busy and undefined codes;
- the one-cycle interrupt latency;
- the ignored reserved bits and address.

// File: rtl/nic_cs_pkg.sv
package nic_cs_pkg;

  localparam int WORD_W    = 16;
  localparam int CAUSE_W   = 8;            // status bits 15:8
  localparam int CU_CODE_W = 4;
  localparam int RU_CODE_W = 3;

  // clearable cause bits within status[15:8] (0xFD00 >> 8)
  localparam logic [CAUSE_W-1:0] CAUSE_LEGAL = 8'hFD;
  localparam int SWI_IDX = 2;              // status bit 10

  // command word bit positions
  localparam int CMD_MASK_BIT = 8;
  localparam int CMD_SWI_BIT  = 9;
  localparam int CMD_CU_LSB   = 4;
  localparam int CMD_RU_LSB   = 0;

  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_CMD    = 2'd1,
    REG_PTR    = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  function automatic logic cu_code_legal(input logic [CU_CODE_W-1:0] c);
    case (c)
      4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd7: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic ru_code_legal(input logic [RU_CODE_W-1:0] c);
    case (c)
      3'd0, 3'd1, 3'd2, 3'd4, 3'd6, 3'd7: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/nic_cmd_slot.sv
module nic_cmd_slot #(
  parameter int CODE_W = 4,
  parameter int PTR_W  = 32,
  parameter bit IS_CU  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [CODE_W-1:0] code_in,
  input  logic [PTR_W-1:0]  ptr_in,
  input  logic              accept,
  output logic              valid,
  output logic [CODE_W-1:0] code,
  output logic [PTR_W-1:0]  ptr,
  output logic              err_pulse
);

  logic              legal;
  logic              valid_q;
  logic [CODE_W-1:0] code_q;
  logic [PTR_W-1:0]  ptr_q;

  generate
    if (IS_CU) begin : g_cu_rules
      assign legal = nic_cs_pkg::cu_code_legal(code_in);
    end else begin : g_ru_rules
      assign legal = nic_cs_pkg::ru_code_legal(code_in);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      code_q  <= '0;
      ptr_q   <= '0;
    end else if (issue && !valid_q && legal) begin
      valid_q <= 1'b1;
      code_q  <= code_in;
      ptr_q   <= ptr_in;
    end else if (valid_q && accept) begin
      valid_q <= 1'b0;
      code_q  <= '0;
    end
  end

  assign err_pulse = issue && (valid_q || !legal);
  assign valid     = valid_q;
  assign code      = code_q;
  assign ptr       = ptr_q;

  // R3: an offered command stays unchanged until taken
  p_hold_until_taken_r3: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !accept) |=> (valid_q && $stable(code_q) && $stable(ptr_q)));

  // R3: accept withdraws the offer on the next cycle
  p_taken_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (valid_q && accept) |=> (!valid_q && code_q == '0));

  generate
    if (IS_CU) begin : g_cu_chk
      // R6: only defined codes are ever offered
      p_only_legal_r6: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> (nic_cs_pkg::cu_code_legal(code_q) && code_q != '0));
    end else begin : g_ru_chk
      p_only_legal_r6: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> (nic_cs_pkg::ru_code_legal(code_q) && code_q != '0));
    end
  endgenerate

endmodule

// File: rtl/nic_cause_reg.sv
module nic_cause_reg
  import nic_cs_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [CAUSE_W-1:0] ev,
  input  logic               swi_set,
  input  logic [CAUSE_W-1:0] clr,
  input  logic               mask,
  output logic [CAUSE_W-1:0] cause,
  output logic               irq
);

  logic [CAUSE_W-1:0] cause_q;
  logic [CAUSE_W-1:0] set_vec;
  logic [CAUSE_W-1:0] swi_vec;
  logic               irq_q;
  logic               hw_pending;

  always_comb begin
    swi_vec          = '0;
    swi_vec[SWI_IDX] = swi_set;
    set_vec          = (ev | swi_vec) & CAUSE_LEGAL;
  end

  always_ff @(posedge clk) begin
    if (rst) cause_q <= '0;
    else     cause_q <= ((cause_q & ~(clr & CAUSE_LEGAL)) | set_vec);
  end

  always_comb begin
    hw_pending = 1'b0;
    for (int i = 0; i < CAUSE_W; i++) begin
      if (i != SWI_IDX && cause_q[i]) hw_pending = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (hw_pending && !mask) || cause_q[SWI_IDX];
  end

  assign cause = cause_q;
  assign irq   = irq_q;

  // R7: a pulse always lands, even against a same-cycle clear
  p_event_kept_r7: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((cause_q & $past(set_vec)) == $past(set_vec)));

  // R8: no pending cause, no interrupt on the following cycle
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (cause_q == '0) |=> !irq_q);

  // R9: the mask holds the line low unless software raised it
  p_mask_gates_r9: assert property (@(posedge clk) disable iff (rst)
    (mask && !cause_q[SWI_IDX]) |=> !irq_q);

endmodule

// File: rtl/nic_cmd_stat.sv
module nic_cmd_stat
  import nic_cs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PTR_W  = 32,
  parameter int ADDR_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  input  logic [CAUSE_W-1:0]   ev_in,
  input  logic [1:0]           cu_state,
  input  logic [3:0]           ru_state,
  output logic                 cu_valid,
  output logic [CU_CODE_W-1:0] cu_code,
  output logic [PTR_W-1:0]     cu_ptr,
  input  logic                 cu_accept,
  output logic                 ru_valid,
  output logic [RU_CODE_W-1:0] ru_code,
  output logic [PTR_W-1:0]     ru_ptr,
  input  logic                 ru_accept,
  output logic                 irq
);

  localparam int PAD_W = DATA_W - WORD_W;

  logic                 wr_status, wr_cmd, wr_ptr;
  logic [WORD_W-1:0]    cmd_in;
  logic [CU_CODE_W-1:0] cu_field;
  logic [RU_CODE_W-1:0] ru_field;
  logic                 mask_q;
  logic                 err_q;
  logic [PTR_W-1:0]     ptr_q;
  logic                 cu_err, ru_err;
  logic [CAUSE_W-1:0]   cause;
  logic [CAUSE_W-1:0]   clr_vec;
  logic [WORD_W-1:0]    status_word, cmd_word;
  logic [DATA_W-1:0]    rd_mux, rd_q;

  // ---- write decode ----
  always_comb begin
    wr_status = wr_en && (wr_addr == ADDR_W'(REG_STATUS));
    wr_cmd    = wr_en && (wr_addr == ADDR_W'(REG_CMD));
    wr_ptr    = wr_en && (wr_addr == ADDR_W'(REG_PTR));
    cmd_in    = wr_data[WORD_W-1:0];
    cu_field  = cmd_in[CMD_CU_LSB +: CU_CODE_W];
    ru_field  = cmd_in[CMD_RU_LSB +: RU_CODE_W];
    clr_vec   = wr_status ? wr_data[WORD_W-1 -: CAUSE_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 1'b1;
      ptr_q  <= '0;
    end else begin
      if (wr_cmd) mask_q <= cmd_in[CMD_MASK_BIT];
      if (wr_ptr) ptr_q  <= wr_data[PTR_W-1:0];
    end
  end

  // ---- per-engine command slots ----
  nic_cmd_slot #(.CODE_W(CU_CODE_W), .PTR_W(PTR_W), .IS_CU(1'b1)) u_cu_slot (
    .clk       (clk),
    .rst       (rst),
    .issue     (wr_cmd && (cu_field != '0)),
    .code_in   (cu_field),
    .ptr_in    (ptr_q),
    .accept    (cu_accept),
    .valid     (cu_valid),
    .code      (cu_code),
    .ptr       (cu_ptr),
    .err_pulse (cu_err)
  );

  nic_cmd_slot #(.CODE_W(RU_CODE_W), .PTR_W(PTR_W), .IS_CU(1'b0)) u_ru_slot (
    .clk       (clk),
    .rst       (rst),
    .issue     (wr_cmd && (ru_field != '0)),
    .code_in   (ru_field),
    .ptr_in    (ptr_q),
    .accept    (ru_accept),
    .valid     (ru_valid),
    .code      (ru_code),
    .ptr       (ru_ptr),
    .err_pulse (ru_err)
  );

  // ---- sticky drop flag, set wins over clear ----
  always_ff @(posedge clk) begin
    if (rst)                        err_q <= 1'b0;
    else if (cu_err || ru_err)      err_q <= 1'b1;
    else if (wr_status && wr_data[0]) err_q <= 1'b0;
  end

  // ---- causes and interrupt ----
  nic_cause_reg u_cause (
    .clk     (clk),
    .rst     (rst),
    .ev      (ev_in),
    .swi_set (wr_cmd && cmd_in[CMD_SWI_BIT]),
    .clr     (clr_vec),
    .mask    (mask_q),
    .cause   (cause),
    .irq     (irq)
  );

  // ---- read path ----
  always_comb begin
    status_word = {cause, cu_state, ru_state, 1'b0, err_q};
    cmd_word    = '0;
    cmd_word[CMD_MASK_BIT]                = mask_q;
    cmd_word[CMD_CU_LSB +: CU_CODE_W]     = cu_code;
    cmd_word[CMD_RU_LSB +: RU_CODE_W]     = ru_code;
    case (rd_addr)
      ADDR_W'(REG_STATUS): rd_mux = {{PAD_W{1'b0}}, status_word};
      ADDR_W'(REG_CMD):    rd_mux = {{PAD_W{1'b0}}, cmd_word};
      ADDR_W'(REG_PTR):    rd_mux = DATA_W'(ptr_q);
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign rd_data = rd_q;

  // R5: a busy engine never gets its offer replaced by a new write
  p_busy_write_dropped_r5: assert property (@(posedge clk) disable iff (rst)
    (cu_valid && !cu_accept && wr_cmd) |=> (cu_valid && $stable(cu_code)));

endmodule

// File: tb/nic_cmd_stat_bench.sv
module nic_cmd_stat_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [1:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [7:0]  ev_in;
  logic [1:0]  cu_state;
  logic [3:0]  ru_state;
  logic        cu_valid, ru_valid, cu_accept, ru_accept, irq;
  logic [3:0]  cu_code;
  logic [2:0]  ru_code;
  logic [31:0] cu_ptr, ru_ptr;

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_fire = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  nic_cmd_stat u_nic_cmd_stat (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .ev_in(ev_in),
    .cu_state(cu_state), .ru_state(ru_state),
    .cu_valid(cu_valid), .cu_code(cu_code), .cu_ptr(cu_ptr), .cu_accept(cu_accept),
    .ru_valid(ru_valid), .ru_code(ru_code), .ru_ptr(ru_ptr), .ru_accept(ru_accept),
    .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(posedge clk) rd_fire <= rd_en;
  always @(negedge clk) begin
    if (rd_fire) begin
      if (exp_q.size() == 0) chk(1'b0, "R12 no expected item", rd_data, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data === e, t, rd_data, e);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] v);
    ev_in = v;
    @(negedge clk);
    ev_in = '0;
  endtask

  task automatic cu_take();
    cu_accept = 1'b1; @(negedge clk); cu_accept = 1'b0;
  endtask

  task automatic ru_take();
    ru_accept = 1'b1; @(negedge clk); ru_accept = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    rst = 1'b1; wr_en = 0; rd_en = 0; wr_addr = 0; rd_addr = 0; wr_data = 0;
    ev_in = 0; cu_state = 0; ru_state = 0; cu_accept = 0; ru_accept = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(!cu_valid && !ru_valid, "R1 valids low", {cu_valid, ru_valid}, 0);
    chk(irq == 1'b0, "R1 irq low", irq, 0);
    rd(0, 32'h0, "R1 status after reset");
    rd(1, 32'h0100, "R1 command after reset");
    rd(2, 32'h0, "R1 pointer after reset");

    // R2 live engine state fields
    cu_state = 2'd2; ru_state = 4'd4;
    @(negedge clk);
    rd(0, 32'h0090, "R2 state fields");
    ru_state = 4'b1100;
    rd(0, 32'h00B0, "R2 receive state with no-descriptor bit");
    ru_state = 4'd4;

    // R4 issue with pointer snapshot
    wr(2, 32'h1234_5678);
    wr(1, 32'h0111);
    chk(cu_valid && cu_code == 4'd1, "R4 cu offered", {cu_valid, cu_code}, {1'b1, 4'd1});
    chk(ru_valid && ru_code == 3'd1, "R4 ru offered", {ru_valid, ru_code}, {1'b1, 3'd1});
    chk(cu_ptr == 32'h1234_5678, "R4 cu pointer", cu_ptr, 32'h1234_5678);
    wr(2, 32'hAAAA_0000);
    chk(cu_ptr == 32'h1234_5678 && ru_ptr == 32'h1234_5678, "R4 snapshot kept", cu_ptr, 32'h1234_5678);
    rd(2, 32'hAAAA_0000, "R4 pointer register");
    rd(1, 32'h0111, "R3 pending fields read back");

    // R5 busy write dropped
    wr(1, 32'h0120);
    chk(cu_code == 4'd1, "R5 busy cu keeps code", cu_code, 4'd1);
    rd(0, 32'h0091, "R5 error flag set");
    wr(0, 32'h0001);
    rd(0, 32'h0090, "R11 error flag cleared");

    // R3 accept
    repeat (3) @(negedge clk);
    chk(cu_valid, "R3 valid held while waiting", cu_valid, 1);
    cu_take();
    chk(!cu_valid && ru_valid, "R3 cu withdrawn", {cu_valid, ru_valid}, 2'b01);
    rd(1, 32'h0101, "R3 cu field zero after accept");
    ru_take();
    rd(1, 32'h0100, "R3 ru field zero after accept");

    // R6 undefined codes
    wr(1, 32'h0130);
    chk(!cu_valid, "R6 cu code 3 dropped", cu_valid, 0);
    rd(0, 32'h0091, "R6 error on cu code 3");
    wr(0, 32'h0001);
    wr(1, 32'h0105);
    chk(!ru_valid, "R6 ru code 5 dropped", ru_valid, 0);
    rd(0, 32'h0091, "R6 error on ru code 5");
    wr(0, 32'h0001);
    wr(1, 32'h0180);
    chk(!cu_valid, "R6 cu code 8 dropped", cu_valid, 0);
    wr(0, 32'h0001);
    rd(0, 32'h0090, "R6 error cleared");

    // R5 zero field has no effect
    wr(1, 32'h0104);
    chk(ru_valid && ru_code == 3'd4, "R5 ru abort offered", ru_code, 3'd4);
    wr(1, 32'h0100);
    rd(0, 32'h0090, "R5 zero field raises no error");
    rd(1, 32'h0104, "R5 pending code untouched");
    ru_take();

    // R7 R8 R9 event, mask, latency
    pulse(8'h80);
    rd(0, 32'h8090, "R7 command-done cause");
    chk(irq == 1'b0, "R9 masked cause keeps irq low", irq, 0);
    wr(1, 32'h0000);
    chk(irq == 1'b0, "R8 irq not yet updated", irq, 0);
    @(negedge clk);
    chk(irq == 1'b1, "R8 irq one cycle after unmask", irq, 1);
    rd(1, 32'h0000, "R9 mask bit reads back clear");
    wr(0, 32'h8000);
    @(negedge clk);
    chk(irq == 1'b0, "R8 irq drops after clear", irq, 0);
    rd(0, 32'h0090, "R7 cause cleared");

    pulse(8'h48);
    rd(0, 32'h4890, "R7 frame and management causes");
    wr(0, 32'h4000);
    rd(0, 32'h0890, "R7 selective clear");
    wr(0, 32'h0800);
    rd(0, 32'h0090, "R7 all clear");

    // R7 same-cycle set and clear
    ev_in = 8'h40; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h4000;
    @(negedge clk);
    ev_in = 0; wr_en = 1'b0;
    rd(0, 32'h4090, "R7 set wins over clear");
    wr(0, 32'h4000);

    // R10 software interrupt bypasses mask
    wr(1, 32'h0100);
    wr(1, 32'h0300);
    @(negedge clk);
    chk(irq == 1'b1, "R10 swi raises irq while masked", irq, 1);
    rd(0, 32'h0490, "R10 swi cause bit");
    rd(1, 32'h0100, "R10 swi bit reads zero");
    wr(0, 32'h0400);
    @(negedge clk);
    chk(irq == 1'b0, "R10 irq drops after swi clear", irq, 0);

    // R9 masked pause cause, then unmask
    pulse(8'h01);
    @(negedge clk);
    chk(irq == 1'b0, "R9 pause masked", irq, 0);
    rd(0, 32'h0190, "R2 pause cause at bit 8");
    wr(1, 32'h0000);
    @(negedge clk);
    chk(irq == 1'b1, "R9 pause unmasked", irq, 1);
    wr(0, 32'h0100);
    wr(1, 32'h0100);

    // R11 reserved bit and unmapped address
    pulse(8'h02);
    rd(0, 32'h0090, "R11 reserved event ignored");
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h0090, "R11 clear of nothing");
    wr(3, 32'hFFFF_FFFF);
    rd(3, 32'h0, "R11 unmapped address reads zero");
    rd(2, 32'hAAAA_0000, "R11 unmapped write left pointer");

    @(negedge clk);
    chk(exp_q.size() == 0, "R12 all reads returned", exp_q.size(), 0);
    finish_run();
  end

endmodule